// File: doc/BRIEF.md
# Multichannel Scan Sequencer and Command Decoder

This block sits between the serial front end of a multichannel converter and its input multiplexer. After each frame, the serial logic presents a 16-bit command word together with a one-cycle frame-done strobe. The block decodes that word and registers the input the converter will sample next.

In automatic mode the sequencer steps through every channel that is eligible, moving up by one eligible channel per frame and wrapping back to the lowest. A channel is eligible when its enable bit is 1 and its front-end power-down bit is 0. In manual mode the sequencer stays on one fixed channel. A third mode routes the auxiliary input instead.

The block also decodes two more commands. The standby command sets a standby flag. The register-reset command sends a one-cycle pulse to the program registers. The most recent frame's command word is held for read-back.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset the block is in manual mode on channel 0, with aux_sel, standby, scan_err and regs_reset all 0 and cmd_readback equal to 0000h.
- R2: Outputs change only on the clock edge at which frame_done is sampled high, so a command affects the next sample. Without frame_done every output holds its value, except that regs_reset falls back to 0.
- R3: cmd_readback takes the full 16-bit command word of every frame, whether or not that word is recognised.
- R4: Command A000h selects automatic mode, clears standby and selects the lowest-numbered eligible channel. A channel is eligible when ch_enable is 1 and ch_pwrdn is 0 for it.
- R5: In automatic mode, a frame whose word is 0000h or any unrecognised word moves to the next higher eligible channel. From the highest eligible channel it wraps to the lowest. Eligibility is taken from the inputs present at that frame.
- R6: In automatic mode with no eligible channel, A000h or a no-operation frame keeps the current channel and sets scan_err. scan_err clears at the next frame that finds an eligible channel, or at any manual, aux or reset command.
- R7: The manual command has bits [15:14] = 11, bits [13:10] = n with n < NUM_CH, and bits [9:0] = 0. For 8 channels these are C000h to DC00h, and code 0111 selects channel 7. It selects manual mode on channel n and clears standby. Later no-operation frames keep channel n. A field value n >= NUM_CH, other than the aux word, is treated as no-operation.
- R8: Command E000h selects the auxiliary input and clears standby, while mux_ch keeps its value. No-operation frames keep the aux selection.
- R9: Command 8200h sets standby and keeps the mode and channel. While in standby, no-operation frames neither advance the scan nor clear standby. A000h, a manual command or E000h leaves standby.
- R10: Command 8500h raises regs_reset for exactly one cycle and returns the sequencer to its R1 state, except that cmd_readback shows 8500h.
- R11: Exactly one of manual_mode, auto_mode and aux_sel is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: cmd_word holds a complete frame |
| cmd_word | input | 16 | Command word of the finished frame |
| ch_enable | input | NUM_CH | Per-channel inclusion in the automatic scan |
| ch_pwrdn | input | NUM_CH | Per-channel front-end power-down; 1 excludes the channel |
| mux_ch | output | CH_W | Selected analog channel |
| aux_sel | output | 1 | Auxiliary input selected |
| auto_mode | output | 1 | Automatic scan mode |
| manual_mode | output | 1 | Fixed-channel mode |
| standby | output | 1 | Standby requested |
| scan_err | output | 1 | Automatic scan found no eligible channel |
| regs_reset | output | 1 | One-cycle program-register reset pulse |
| cmd_readback | output | 16 | Command word of the last frame |

## Verification
On every cycle the assertions check several behaviours:
- exactly one mode flag is set;
- outputs hold between frames;
- read-back follows each frame's word;
- a manual command selects its channel;
- standby is entered on command;
- the reset pulse appears only after a reset command;
- an automatic restart with eligible channels lands on a channel that was eligible.

Some behaviours only the bench scenarios can show, because they depend on the order of several frames:
- that the lowest eligible channel is chosen;
- the exact stepping order and wrap;
- skipping channels that are enabled but powered down;
- the hold and error behaviour when no channel is eligible;
- that standby freezes the scan.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
  localparam int CMD_W = 16;

  localparam logic [CMD_W-1:0] CMD_NOP     = 16'h0000;
  localparam logic [CMD_W-1:0] CMD_AUTO    = 16'hA000;
  localparam logic [CMD_W-1:0] CMD_AUX     = 16'hE000;
  localparam logic [CMD_W-1:0] CMD_STANDBY = 16'h8200;
  localparam logic [CMD_W-1:0] CMD_REGRST  = 16'h8500;

  typedef enum logic [2:0] {
    K_NOP, K_AUTO, K_MAN, K_AUX, K_STBY, K_RST
  } cmd_kind_e;

  typedef enum logic [1:0] {
    M_MAN, M_AUTO, M_AUX
  } scan_mode_e;

  // A fixed-channel word: top bits 11, 4-bit channel in [13:10], low ten bits zero.
  function automatic logic is_manual_word(input logic [CMD_W-1:0] w, input int num_ch);
    return (w[15:14] == 2'b11) && (w[9:0] == 10'd0) && (int'(w[13:10]) < num_ch);
  endfunction

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] w, input int num_ch);
    cmd_kind_e k;
    if (w == CMD_AUTO)               k = K_AUTO;
    else if (w == CMD_AUX)           k = K_AUX;
    else if (w == CMD_STANDBY)       k = K_STBY;
    else if (w == CMD_REGRST)        k = K_RST;
    else if (is_manual_word(w, num_ch)) k = K_MAN;
    else                             k = K_NOP;
    return k;
  endfunction
endpackage

// File: rtl/scan_cmd_decode.sv
module scan_cmd_decode
  import chan_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [CMD_W-1:0] cmd,
  output cmd_kind_e        kind,
  output logic [CH_W-1:0]  man_ch
);
  always_comb begin
    kind   = classify(cmd, NUM_CH);
    man_ch = cmd[10 +: CH_W];
  end
endmodule

// File: rtl/scan_elig_pick.sv
module scan_elig_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic [CH_W-1:0]   cur,
  output logic [CH_W-1:0]   lowest,
  output logic [CH_W-1:0]   next,
  output logic              any
);
  always_comb begin
    any    = |elig;
    lowest = cur;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) lowest = CH_W'(i);
    end
    // Search cur+1 upward with wrap; the last step (k = NUM_CH) is cur itself.
    next = cur;
    for (int k = NUM_CH; k >= 1; k--) begin
      int t;
      t = int'(cur) + k;
      if (t >= NUM_CH) t = t - NUM_CH;
      if (elig[t]) next = CH_W'(t);
    end
  end
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [15:0]       cmd_word,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_pwrdn,
  output logic [CH_W-1:0]   mux_ch,
  output logic              aux_sel,
  output logic              auto_mode,
  output logic              manual_mode,
  output logic              standby,
  output logic              scan_err,
  output logic              regs_reset,
  output logic [15:0]       cmd_readback
);
  cmd_kind_e        kind;
  logic [CH_W-1:0]  man_ch;
  logic [NUM_CH-1:0] elig_w;
  logic [CH_W-1:0]  low_ch, nxt_ch;
  logic             any_elig;

  scan_mode_e       mode_q;
  logic [CH_W-1:0]  ch_q;
  logic             stby_q, err_q, rst_pulse_q;
  logic [15:0]      rb_q;

  // Named internal events for the checker
  logic             scan_step_w;
  logic             restart_w;

  assign elig_w      = ch_enable & ~ch_pwrdn;
  assign scan_step_w = frame_done && (kind == K_NOP) && !stby_q && (mode_q == M_AUTO);
  assign restart_w   = frame_done && (kind == K_AUTO);

  scan_cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .cmd    (cmd_word),
    .kind   (kind),
    .man_ch (man_ch)
  );

  scan_elig_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .elig   (elig_w),
    .cur    (ch_q),
    .lowest (low_ch),
    .next   (nxt_ch),
    .any    (any_elig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_MAN;
      ch_q        <= '0;
      stby_q      <= 1'b0;
      err_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
      rb_q        <= '0;
    end else begin
      rst_pulse_q <= 1'b0;
      if (frame_done) begin
        rb_q <= cmd_word;
        case (kind)
          K_AUTO: begin
            mode_q <= M_AUTO;
            stby_q <= 1'b0;
            if (any_elig) begin
              ch_q  <= low_ch;
              err_q <= 1'b0;
            end else begin
              err_q <= 1'b1;
            end
          end
          K_MAN: begin
            mode_q <= M_MAN;
            ch_q   <= man_ch;
            stby_q <= 1'b0;
            err_q  <= 1'b0;
          end
          K_AUX: begin
            mode_q <= M_AUX;
            stby_q <= 1'b0;
            err_q  <= 1'b0;
          end
          K_STBY: begin
            stby_q <= 1'b1;
          end
          K_RST: begin
            mode_q      <= M_MAN;
            ch_q        <= '0;
            stby_q      <= 1'b0;
            err_q       <= 1'b0;
            rst_pulse_q <= 1'b1;
          end
          default: begin
            if (scan_step_w) begin
              if (any_elig) begin
                ch_q  <= nxt_ch;
                err_q <= 1'b0;
              end else begin
                err_q <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign mux_ch       = ch_q;
  assign aux_sel      = (mode_q == M_AUX);
  assign auto_mode    = (mode_q == M_AUTO);
  assign manual_mode  = (mode_q == M_MAN);
  assign standby      = stby_q;
  assign scan_err     = err_q;
  assign regs_reset   = rst_pulse_q;
  assign cmd_readback = rb_q;
endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic [15:0]       cmd_word,
  input logic [NUM_CH-1:0] elig_w,
  input logic              restart_w,
  input logic [CH_W-1:0]   mux_ch,
  input logic              aux_sel,
  input logic              auto_mode,
  input logic              manual_mode,
  input logic              standby,
  input logic              regs_reset,
  input logic [15:0]       cmd_readback
);
  logic [NUM_CH-1:0] elig_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_prev <= '0;
    else        elig_prev <= elig_w;
  end

  logic man_word;
  assign man_word = (cmd_word[15:14] == 2'b11) && (cmd_word[9:0] == 10'd0)
                    && (int'(cmd_word[13:10]) < NUM_CH);

  assert_one_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({aux_sel, auto_mode, manual_mode}) == 1);

  assert_hold_between_frames_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(mux_ch) && $stable(cmd_readback) && $stable(standby)
                    && $stable(auto_mode) && $stable(aux_sel));

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cmd_readback == $past(cmd_word));

  assert_restart_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w && (|elig_w) |=> auto_mode && elig_prev[mux_ch]);

  assert_manual_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && man_word |=> manual_mode && (mux_ch == $past(cmd_word[10 +: CH_W])));

  assert_standby_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && (cmd_word == 16'h8200) |=> standby);

  assert_reset_pulse_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |-> $past(frame_done && (cmd_word == 16'h8500)));
endmodule

bind chan_scan_seq chan_scan_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_done   (frame_done),
  .cmd_word     (cmd_word),
  .elig_w       (elig_w),
  .restart_w    (restart_w),
  .mux_ch       (mux_ch),
  .aux_sel      (aux_sel),
  .auto_mode    (auto_mode),
  .manual_mode  (manual_mode),
  .standby      (standby),
  .regs_reset   (regs_reset),
  .cmd_readback (cmd_readback)
);

// File: tb/sim_chan_scan_seq.sv
module sim_chan_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [NCH-1:0] ch_enable = '0;
  logic [NCH-1:0] ch_pwrdn = '0;
  logic [2:0] mux_ch;
  logic aux_sel, auto_mode, manual_mode, standby, scan_err, regs_reset;
  logic [15:0] cmd_readback;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_scan_seq #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cmd_word(cmd_word),
    .ch_enable(ch_enable), .ch_pwrdn(ch_pwrdn), .mux_ch(mux_ch),
    .aux_sel(aux_sel), .auto_mode(auto_mode), .manual_mode(manual_mode),
    .standby(standby), .scan_err(scan_err), .regs_reset(regs_reset),
    .cmd_readback(cmd_readback)
  );

  typedef struct {
    logic [24:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench reference state: 0 manual, 1 auto, 2 aux
  int m_mode = 0;
  int m_ch = 0;
  bit m_stby = 0;
  bit m_err = 0;
  bit m_pulse = 0;
  logic [15:0] m_rb = '0;

  function automatic logic [24:0] pack(int mode, int ch, bit sb, bit er, bit pl, logic [15:0] rb);
    return {pl, er, sb, mode == 2, mode == 1, mode == 0, 3'(ch), rb};
  endfunction

  function automatic logic [24:0] observed();
    return {regs_reset, scan_err, standby, aux_sel, auto_mode, manual_mode, mux_ch, cmd_readback};
  endfunction

  task automatic check(logic [24:0] act, logic [24:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one frame, written from the requirements
  task automatic model(logic [15:0] w, logic [NCH-1:0] el);
    int lo;
    int nx;
    m_rb = w;
    m_pulse = 0;
    lo = -1;
    for (int i = 0; i < NCH; i++) if (el[i] && lo < 0) lo = i;
    nx = -1;
    for (int s = 1; s <= NCH; s++) if (nx < 0 && el[(m_ch + s) % NCH]) nx = (m_ch + s) % NCH;
    if (w == 16'hA000) begin
      m_mode = 1; m_stby = 0;
      if (lo < 0) m_err = 1; else begin m_ch = lo; m_err = 0; end
    end else if (w == 16'hE000) begin
      m_mode = 2; m_stby = 0; m_err = 0;
    end else if (w == 16'h8200) begin
      m_stby = 1;
    end else if (w == 16'h8500) begin
      m_mode = 0; m_ch = 0; m_stby = 0; m_err = 0; m_pulse = 1;
    end else if (w[15:14] == 2'b11 && w[9:0] == 0 && w[13:10] < NCH) begin
      m_mode = 0; m_ch = int'(w[13:10]); m_stby = 0; m_err = 0;
    end else if (!m_stby && m_mode == 1) begin
      if (nx < 0) m_err = 1; else begin m_ch = nx; m_err = 0; end
    end
  endtask

  task automatic send(logic [15:0] w, logic [NCH-1:0] en, logic [NCH-1:0] pd, string tag);
    exp_t e;
    @(negedge clk);
    cmd_word = w; ch_enable = en; ch_pwrdn = pd; frame_done = 1'b1;
    model(w, en & ~pd);
    e.val = pack(m_mode, m_ch, m_stby, m_err, m_pulse, m_rb);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    frame_done = 1'b0;
    cmd_word = 16'h5A5A;
  endtask

  task automatic idle_check(int cycles, string tag);
    wait (exp_q.size() == 0);
    repeat (cycles) @(negedge clk);
    check(observed(), pack(m_mode, m_ch, m_stby, m_err, 0, m_rb), tag);
  endtask

  // Monitor: pops one expected item per frame, compares after the update edge
  initial begin
    forever begin
      @(posedge clk);
      if (frame_done) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        check(observed(), e.val, e.tag);
        // R11: one mode flag per compared state
        check(32'($countones({aux_sel, auto_mode, manual_mode})), 32'd1, "R11");
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(observed(), pack(0, 0, 0, 0, 0, 16'h0000), "R1 reset state");

    // eligible = 1011_0010 -> ch 1,4,5,7 (ch2 enabled but powered down)
    send(16'hA000, 8'b1011_0110, 8'b0000_0100, "R4 restart lowest eligible");
    send(16'h0000, 8'b1011_0110, 8'b0000_0100, "R5 step 1->4");
    send(16'h0000, 8'b1011_0110, 8'b0000_0100, "R5 step 4->5");
    send(16'h0000, 8'b1011_0110, 8'b0000_0100, "R5 step 5->7");
    send(16'h0000, 8'b1011_0110, 8'b0000_0100, "R5 wrap 7->1");
    send(16'h1234, 8'b1011_0110, 8'b0000_0100, "R5 R3 unrecognised word steps");
    send(16'h0000, 8'b1011_0110, 8'b0010_0100, "R5 skip powered-down ch5");
    send(16'h0000, 8'h00, 8'h00, "R6 no eligible hold+err");
    send(16'hA000, 8'hF0, 8'hF0, "R6 restart with none eligible");
    send(16'hCC00, 8'hFF, 8'h00, "R7 manual ch3");
    send(16'h0000, 8'hFF, 8'h00, "R7 manual holds on nop");
    send(16'hDC00, 8'hFF, 8'h00, "R7 manual ch7 code 0111");
    send(16'hE400, 8'hFF, 8'h00, "R7 out-of-range field is nop");
    send(16'hE000, 8'hFF, 8'h00, "R8 aux select");
    send(16'h0000, 8'hFF, 8'h00, "R8 aux holds on nop");
    send(16'h8200, 8'hFF, 8'h00, "R9 standby from aux");
    send(16'h0000, 8'hFF, 8'h00, "R9 standby holds");
    send(16'hA000, 8'hFF, 8'h00, "R9 R4 restart leaves standby");
    send(16'h8200, 8'hFF, 8'h00, "R9 standby in auto");
    send(16'h0000, 8'hFF, 8'h00, "R9 no advance in standby");
    send(16'hC400, 8'hFF, 8'h00, "R9 R7 manual leaves standby");
    send(16'hA000, 8'h0C, 8'h00, "R4 restart at ch2");
    send(16'h0000, 8'h0C, 8'h00, "R5 step 2->3");
    send(16'h8500, 8'h0C, 8'h00, "R10 register reset");
    idle_check(1, "R10 pulse ends after one cycle");
    idle_check(5, "R2 outputs hold between frames");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule